// File: doc/BRIEF.md
# Audio Noise Gate Controller

This block sits on one digitized audio channel and decides when the channel should be gated. Each sample arrives with a strobe and with a signed level estimate. The level is counted in steps of 1.5 dB, and 0 means full scale. The block compares that level against a programmable threshold. It gates only after the level has stayed below the threshold for a qualification timeout of 250 ms. Once gated, it releases only when the level rises past a second threshold placed 6 dB higher. The hysteresis band stops the gate from chattering around a single trip point.

A two-bit mode selects what gating does. In the hold mode the samples still pass, and a hold request asks an external gain controller to freeze its gain. In every other mode the output samples are forced to zero. A registered gate-active flag is also provided, so downstream logic can follow the gate state. The level detector and the gain loop are outside this block.

Top module: `noise_gate_ctrl`

## Requirements
- R1: While `enable` is 0, every strobed sample appears unchanged on `out_data`, and `gate_active` and `hold_req` stay 0.
- R2: Threshold code `c` (5 bits) sets the engage level to `c - THR_SPAN` level steps, where THR_SPAN defaults to 51 and one step is 1.5 dB. A strobed sample counts as quiet only when `in_level` is strictly below that engage level.
- R3: The gate engages on the strobe that completes TIMEOUT consecutive quiet strobes. TIMEOUT = SAMPLE_RATE_HZ * 250 / 1000, which is 12000 at 48 kHz. `gate_active` is 1 after that edge.
- R4: A strobed sample whose level is at or above the engage level restarts the qualification count from zero.
- R5: The release level is `min(c + 4, 31) - THR_SPAN` steps. While gated, the gate stays active when the level equals the release level or lies below it. The gate releases on the first strobe whose level exceeds the release level.
- R6: Mode 0 (hold): while the gate is active, the samples pass unchanged and `hold_req` is 1.
- R7: Mode 1 (mute): while the gate is active, `out_data` is zero and `hold_req` is 0.
- R8: Modes 2 and 3 behave exactly like mode 1.
- R9: A change of mode or threshold code takes effect at the next strobe. The gate state is kept across the change.
- R10: When `enable` goes to 0, `gate_active` and `hold_req` fall on the next clock edge, with or without a strobe. The qualification count is also cleared, so a full TIMEOUT of quiet strobes is needed after re-enabling.
- R11: Apart from the release caused by `enable`, `gate_active` and `hold_req` change only on strobe edges.
- R12: `out_valid` repeats `in_valid` one clock later. `out_data` is registered on each strobe and holds its value between strobes. The mute decision uses the gate state produced by that same strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Gate enable |
| gate_mode | input | 2 | 0 hold, 1 mute, 2 and 3 mute |
| thr_code | input | 5 | Engage threshold code |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Input sample |
| in_level | input | LVL_W | Signed level estimate, in 1.5 dB steps |
| out_valid | output | 1 | Output strobe |
| out_data | output | DATA_W | Gated sample |
| gate_active | output | 1 | Gate engaged flag |
| hold_req | output | 1 | Gain freeze request |

## Verification
A qualification count in the wrong state shows up only as a shift in the strobe on which `gate_active` rises. The bench therefore places a restart one strobe before the expected expiry and checks the exact engaging strobe. A hysteresis comparison built the wrong way shows up one strobe after a level equal to the release level: the gate drops although it should have held. Near the top code, the same fault appears as a gate that releases at the wrong level. A wrong mode decode shows up on the very next strobe, either as a non-zero `out_data` or as a `hold_req` that is set or cleared wrongly. Random phases mix strobe gaps, enable drops and mode changes, and they compare every output on every cycle.

// File: rtl/ngate_pkg.sv
package ngate_pkg;

  localparam int THR_W = 5;

  typedef enum logic [1:0] {
    GMODE_HOLD = 2'd0,
    GMODE_MUTE = 2'd1,
    GMODE_RSV2 = 2'd2,
    GMODE_RSV3 = 2'd3
  } gate_mode_e;

  // Engage level in 1.5 dB steps relative to full scale.
  function automatic int engage_level(input logic [THR_W-1:0] code, input int span);
    return int'({{(32-THR_W){1'b0}}, code}) - span;
  endfunction

  // Release code: engage code raised by the hysteresis, saturated at the top code.
  function automatic logic [THR_W-1:0] release_code(input logic [THR_W-1:0] code,
                                                     input logic [THR_W-1:0] hyst);
    logic [THR_W:0] sum;
    sum = {1'b0, code} + {1'b0, hyst};
    return sum[THR_W] ? {THR_W{1'b1}} : sum[THR_W-1:0];
  endfunction

  // Every mode except hold zeroes the data while gated.
  function automatic logic mode_mutes(input logic [1:0] mode);
    return mode != GMODE_HOLD;
  endfunction

  function automatic logic mode_holds(input logic [1:0] mode);
    return mode == GMODE_HOLD;
  endfunction

endpackage

// File: rtl/ngate_level_cmp.sv
module ngate_level_cmp
  import ngate_pkg::*;
#(
  parameter int LVL_W     = 8,
  parameter int THR_SPAN  = 51,
  parameter int HYST_CODE = 4
) (
  input  logic signed [LVL_W-1:0] level,
  input  logic [THR_W-1:0]        code,
  output logic                    below_engage,
  output logic                    above_release
);

  localparam logic [THR_W-1:0] HYST = THR_W'(HYST_CODE);

  int lvl_i;
  int eng_i;
  int rel_i;

  always_comb begin
    lvl_i         = int'(level);
    eng_i         = engage_level(code, THR_SPAN);
    rel_i         = engage_level(release_code(code, HYST), THR_SPAN);
    below_engage  = lvl_i < eng_i;
    above_release = lvl_i > rel_i;
  end

  // The release point never lies below the engage point.
  always_comb begin
    assert_band_order_R5: assert (!(below_engage && above_release))
      else $error("level both below engage and above release");
  end

endmodule

// File: rtl/ngate_qual_timer.sv
module ngate_qual_timer #(
  parameter int TIMEOUT = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic strobe,
  input  logic below,
  input  logic above_rel,
  output logic gated_q,
  output logic gate_next
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             expire;

  assign expire = (cnt_q == LAST);

  always_comb begin
    gate_next = gated_q;
    cnt_d     = cnt_q;
    if (!enable) begin
      gate_next = 1'b0;
      cnt_d     = '0;
    end else if (strobe) begin
      if (!gated_q) begin
        if (!below) begin
          cnt_d = '0;
        end else if (expire) begin
          gate_next = 1'b1;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (above_rel) begin
        gate_next = 1'b0;
        cnt_d     = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gated_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      gated_q <= gate_next;
      cnt_q   <= cnt_d;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(TIMEOUT))
    else $error("qualification count out of range");

  assert_engage_on_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gated_q) |-> ($past(cnt_q) == LAST && $past(below) && $past(strobe)))
    else $error("gate engaged without full timeout");

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && strobe && !gated_q && !below) |=> (cnt_q == '0 && !gated_q))
    else $error("loud sample did not restart count");

  assert_release_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gated_q) |-> (($past(strobe) && $past(above_rel)) || !$past(enable)))
    else $error("gate released without cause");

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0))
    else $error("count survived disable");

endmodule

// File: rtl/ngate_out_path.sv
module ngate_out_path
  import ngate_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              strobe,
  input  logic [DATA_W-1:0] in_data,
  input  logic              gate_next,
  output logic              mute_now,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              hold_req
);

  logic hold_now;

  assign mute_now = enable && gate_next && mode_mutes(mode);
  assign hold_now = enable && gate_next && mode_holds(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      hold_req  <= 1'b0;
    end else begin
      out_valid <= strobe;
      if (strobe) out_data <= mute_now ? '0 : in_data;
      if (!enable) hold_req <= 1'b0;
      else if (strobe) hold_req <= hold_now;
    end
  end

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(strobe)))
    else $error("out_valid misaligned");

  assert_data_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(out_data))
    else $error("out_data moved without strobe");

endmodule

// File: rtl/noise_gate_ctrl.sv
module noise_gate_ctrl
  import ngate_pkg::*;
#(
  parameter int DATA_W         = 24,
  parameter int LVL_W          = 8,
  parameter int SAMPLE_RATE_HZ = 48000,
  parameter int GATE_MS        = 250,
  parameter int THR_SPAN       = 51,
  parameter int HYST_CODE      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [1:0]              gate_mode,
  input  logic [4:0]              thr_code,
  input  logic                    in_valid,
  input  logic [DATA_W-1:0]       in_data,
  input  logic signed [LVL_W-1:0] in_level,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_data,
  output logic                    gate_active,
  output logic                    hold_req
);

  localparam int TIMEOUT = (SAMPLE_RATE_HZ * GATE_MS) / 1000;

  logic below_engage;
  logic above_release;
  logic gate_next;
  logic mute_now;

  ngate_level_cmp #(
    .LVL_W(LVL_W), .THR_SPAN(THR_SPAN), .HYST_CODE(HYST_CODE)
  ) u_cmp (
    .level(in_level), .code(thr_code),
    .below_engage(below_engage), .above_release(above_release)
  );

  ngate_qual_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(in_valid),
    .below(below_engage), .above_rel(above_release),
    .gated_q(gate_active), .gate_next(gate_next)
  );

  ngate_out_path #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(gate_mode),
    .strobe(in_valid), .in_data(in_data), .gate_next(gate_next),
    .mute_now(mute_now), .out_valid(out_valid), .out_data(out_data),
    .hold_req(hold_req)
  );

  assert_disable_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!gate_active && !hold_req))
    else $error("disable did not release gate");

  assert_pass_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !enable) |=> (out_data == $past(in_data)))
    else $error("sample modified while disabled");

  assert_hold_implies_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |-> gate_active)
    else $error("hold request without gate");

  assert_hold_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enable && gate_mode == GMODE_HOLD) |=> (out_data == $past(in_data)))
    else $error("hold mode altered data");

  assert_mute_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mute_now) |=> (out_data == '0 && !hold_req))
    else $error("muted sample not zero");

  assert_flags_on_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !in_valid) |=> ($stable(gate_active) && $stable(hold_req)))
    else $error("flag moved between strobes");

endmodule

// File: tb/noise_gate_ctrl_test.sv
module noise_gate_ctrl_test;

  localparam int DW   = 24;
  localparam int LW   = 8;
  localparam int RATE = 400;
  localparam int TOUT = RATE * 250 / 1000;
  localparam int SPAN = 51;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] gate_mode = 2'd0;
  logic [4:0] thr_code = 5'd0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic signed [LW-1:0] in_level = '0;
  logic out_valid;
  logic [DW-1:0] out_data;
  logic gate_active;
  logic hold_req;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  int m_cnt = 0;
  bit m_gate = 1'b0;
  bit m_hold = 1'b0;
  logic [DW-1:0] m_data = '0;
  bit m_valid = 1'b0;

  always #10 clk = ~clk;

  noise_gate_ctrl #(
    .DATA_W(DW), .LVL_W(LW), .SAMPLE_RATE_HZ(RATE), .GATE_MS(250),
    .THR_SPAN(SPAN), .HYST_CODE(4)
  ) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .gate_mode(gate_mode),
    .thr_code(thr_code), .in_valid(in_valid), .in_data(in_data),
    .in_level(in_level), .out_valid(out_valid), .out_data(out_data),
    .gate_active(gate_active), .hold_req(hold_req)
  );

  function automatic int eng_of(input int code);
    return code - SPAN;
  endfunction

  function automatic int rel_of(input int code);
    int r;
    r = code + 4;
    if (r > 31) r = 31;
    return r - SPAN;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // One clock: apply inputs at the falling edge, advance the reference, check at the next falling edge.
  task automatic cyc(input bit v, input logic [DW-1:0] d, input int l, input bit e,
                     input logic [1:0] m, input int c, input string tag);
    in_valid = v; in_data = d; in_level = LW'(l); enable = e;
    gate_mode = m; thr_code = 5'(c);
    if (!e) begin
      m_gate = 0; m_cnt = 0; m_hold = 0;
    end else if (v) begin
      if (!m_gate) begin
        if (l < eng_of(c)) begin
          if (m_cnt + 1 >= TOUT) begin m_gate = 1; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end else m_cnt = 0;
      end else if (l > rel_of(c)) begin
        m_gate = 0; m_cnt = 0;
      end
      m_hold = m_gate && (m == 2'd0);
    end
    if (v) m_data = (e && m_gate && m != 2'd0) ? '0 : d;
    m_valid = v;
    @(negedge clk);
    check(tag, "out_data", 32'(out_data), 32'(m_data));
    check(tag, "out_valid", 32'(out_valid), 32'(m_valid));
    check(tag, "gate_active", 32'(gate_active), 32'(m_gate));
    check(tag, "hold_req", 32'(hold_req), 32'(m_hold));
  endtask

  task automatic run(input int n, input int l, input bit e, input logic [1:0] m,
                     input int c, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, DW'($urandom), l, e, m, c, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R12", "reset out_valid", 32'(out_valid), 32'd0);
    check("R12", "reset out_data", 32'(out_data), 32'd0);
    check("R11", "reset gate_active", 32'(gate_active), 32'd0);
    check("R6", "reset hold_req", 32'(hold_req), 32'd0);
    rst_n = 1'b1;

    // R1: disabled, quiet input far below any threshold
    run(TOUT + 20, -100, 1'b0, 2'd1, 10, "R1");

    // R2 and R4: equal level restarts the count one strobe before expiry
    run(TOUT - 1, -42, 1'b1, 2'd1, 10, "R3");
    cyc(1'b1, 24'h123456, -41, 1'b1, 2'd1, 10, "R2");
    check("R4", "no engage after restart", 32'(gate_active), 32'd0);
    run(TOUT - 1, -45, 1'b1, 2'd1, 10, "R3");
    check("R3", "not yet gated", 32'(gate_active), 32'd0);
    cyc(1'b1, 24'h0abcde, -45, 1'b1, 2'd1, 10, "R3");
    check("R3", "gated at timeout", 32'(gate_active), 32'd1);
    check("R7", "muted sample", 32'(out_data), 32'd0);
    // R5: level at the release point holds, one above releases
    run(5, -37, 1'b1, 2'd1, 10, "R5");
    check("R5", "held at release level", 32'(gate_active), 32'd1);
    cyc(1'b1, 24'h55aa55, -36, 1'b1, 2'd1, 10, "R5");
    check("R5", "released above", 32'(gate_active), 32'd0);
    check("R5", "released sample passes", 32'(out_data), 32'h55aa55);

    // R6: hold mode
    run(TOUT, -60, 1'b1, 2'd0, 10, "R6");
    cyc(1'b1, 24'h777777, -60, 1'b1, 2'd0, 10, "R6");
    check("R6", "hold request", 32'(hold_req), 32'd1);
    check("R6", "data passes", 32'(out_data), 32'h777777);
    // R9 and R11: mode change without strobe leaves flags, next strobe applies it
    for (int i = 0; i < 4; i++) cyc(1'b0, 24'h1, -60, 1'b1, 2'd1, 10, "R11");
    check("R11", "hold kept between strobes", 32'(hold_req), 32'd1);
    cyc(1'b1, 24'h333333, -60, 1'b1, 2'd1, 10, "R9");
    check("R9", "mute after mode change", 32'(out_data), 32'd0);
    check("R9", "hold dropped", 32'(hold_req), 32'd0);
    // R8: reserved modes mute
    run(3, -60, 1'b1, 2'd2, 10, "R8");
    check("R8", "mode 2 mutes", 32'(out_data), 32'd0);
    run(3, -60, 1'b1, 2'd3, 10, "R8");
    check("R8", "mode 3 mutes", 32'(out_data), 32'd0);

    // R10: disable without strobe releases at the next edge
    cyc(1'b0, 24'h0, -60, 1'b0, 2'd1, 10, "R10");
    check("R10", "released on disable", 32'(gate_active), 32'd0);
    run(TOUT - 1, -60, 1'b1, 2'd1, 10, "R10");
    check("R10", "count was cleared", 32'(gate_active), 32'd0);
    cyc(1'b1, 24'h9, -60, 1'b1, 2'd1, 10, "R10");

    // R5 saturation at top codes
    run(3, -19, 1'b1, 2'd1, 30, "R5");
    run(TOUT, -25, 1'b1, 2'd1, 30, "R5");
    run(4, -20, 1'b1, 2'd1, 30, "R5");
    check("R5", "saturated release holds", 32'(gate_active), 32'd1);
    cyc(1'b1, 24'h42, -19, 1'b1, 2'd1, 30, "R5");
    check("R5", "saturated release", 32'(gate_active), 32'd0);
    run(TOUT + 5, -20, 1'b1, 2'd1, 31, "R2");
    check("R2", "equal never engages", 32'(gate_active), 32'd0);

    // Constrained random phases
    for (int p = 0; p < 40; p++) begin
      int c;
      logic [1:0] m;
      c = int'($urandom_range(0, 31));
      m = 2'($urandom_range(0, 3));
      for (int i = 0; i < TOUT + 60; i++) begin
        int l;
        bit v, e;
        v = ($urandom_range(0, 3) != 0);
        e = ($urandom_range(0, 199) != 0);
        if ($urandom_range(0, 63) == 0) l = rel_of(c) + int'($urandom_range(0, 3));
        else l = eng_of(c) - int'($urandom_range(1, 6));
        if (i > TOUT + 30) l = rel_of(c) + int'($urandom_range(0, 2)) - 1;
        if ($urandom_range(0, 99) == 0) m = 2'($urandom_range(0, 3));
        cyc(v, DW'($urandom), l, e, m, c, "R12");
      end
    end

    finish_run();
  end

endmodule